// File: doc/BRIEF.md
# Segmented Multi-Lane Bus Connection Allocator

This block manages a row of processing elements that share a small number of parallel bus lanes. Each lane is cut into segments, one segment between every pair of neighbouring elements. A crosspoint switch joins two neighbouring segments, and a tap switch attaches an element to a lane. When an element asks to talk to another element, the allocator looks for a lane on which every segment between the two is idle. It then closes those segments and the taps at both ends, and acknowledges the sender. Because only the spanned segments are taken, several disjoint transfers can share one lane at the same time.

A path belongs to its sender until the sender releases it. Nothing can preempt it. At most one request is answered per cycle. Among the requests that can be answered in that cycle, the lowest element index wins. A request that cannot be placed yet simply waits, and it is re-examined every cycle. Malformed requests are refused with an error pulse. The switch-control outputs come from registers, so the switch settings for a grant or a release appear on the cycle after the response.

Top module: `rmb_interconnect`

## Requirements
- R1: During reset, and until two clock cycles after `rst_n` rises, `seg_link`, `tap`, `gnt` and `err` are all zero and requests are ignored.
- R2: A request from element s to element d that is answered with a grant raises `gnt[s]` for one cycle, during the cycle in which the request is presented, and drives the chosen lane L on `gnt_lane`. From the next cycle on, `seg_link[L*(N_PE-1)+j]` is 1 for every j with min(s,d) <= j < max(s,d). In the same cycles, `tap[L*N_PE+s]` and `tap[L*N_PE+d]` are 1.
- R3: The lane chosen is the lowest-numbered lane whose segments across the span are all idle. The direction of the transfer (d above or below s) does not matter.
- R4: If no lane has the whole span idle, no pulse is given for that element. The request is examined again every cycle while `req_valid` stays high, and it is granted in the first cycle in which a lane is free.
- R5: At most one of all `gnt` and `err` bits is high in any cycle. The one answered is the lowest-indexed element whose request can be answered now, either by a grant or by an error. A lower-indexed request that is stalled does not block a higher-indexed one.
- R6: A request whose destination equals its source, whose destination is not below `N_PE`, or whose source already holds a path gets an `err` pulse instead of a grant. `seg_link` and `tap` stay unchanged.
- R7: A held path stays exactly as granted until its sender raises `req_rel`. On the next cycle, all of its segments and taps open together. A release from an element holding no path changes nothing.
- R8: Two paths whose spans share no segment can be placed on the same lane, even when they meet at one element.
- R9: No segment of any lane is ever part of two held paths.
- R10: A release and a grant can happen in the same cycle. The grant decision uses the occupancy from before the release, so segments freed by the release become usable one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_PE (6) | Connect request, one bit per source element, held until answered |
| req_dst | input | N_PE*IW (18) | Destination index per source element, IW bits each |
| req_rel | input | N_PE (6) | Release of the path held by that element |
| gnt | output | N_PE (6) | Grant pulse for the answered source element |
| err | output | N_PE (6) | Error pulse for the answered source element |
| gnt_lane | output | LW (2) | Lane of the current grant, zero otherwise |
| seg_link | output | N_LANE*(N_PE-1) (15) | Segment crosspoint closed, bit lane*(N_PE-1)+segment |
| tap | output | N_LANE*N_PE (18) | Element tap closed, bit lane*N_PE+element |

## Verification
A release and a new request can arrive in the same cycle, so the release of one path and the grant of another coincide. The bench creates this case twice. In the first case, the request can use a segment the release does not touch, and it is expected to be granted immediately while the released segments open on the same edge. In the second case, the request needs exactly the segments being released, so no pulse is expected in the release cycle and the grant is expected one cycle later on the freed lane. Both cases are judged by the response pulse and the lane, and by comparing `seg_link` and `tap` to an independent occupancy model afterwards.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
  // Index width that stays at least one bit for a count of one.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/rmb_lane_finder.sv
module rmb_lane_finder #(
  parameter int N_PE   = 6,
  parameter int N_LANE = 3,
  parameter int SRC    = 0,
  parameter int IW     = 3,
  parameter int LW     = 2,
  parameter int N_SEG  = 5
)(
  input  logic [IW-1:0]           dst,
  input  logic [N_LANE*N_SEG-1:0] seg_busy,
  output logic [N_SEG-1:0]        span,
  output logic                    found,
  output logic [LW-1:0]           lane
);
  localparam logic [IW-1:0] SRC_V = IW'(SRC);

  logic [IW-1:0]     lo;
  logic [IW-1:0]     hi;
  logic [N_LANE-1:0] lane_ok;

  // Segments from the lower endpoint up to the upper one.
  always_comb begin
    lo = (dst < SRC_V) ? dst : SRC_V;
    hi = (dst < SRC_V) ? SRC_V : dst;
    for (int j = 0; j < N_SEG; j++) begin
      span[j] = (IW'(j) >= lo) && (IW'(j) < hi);
    end
  end

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    assign lane_ok[l] = ~|(seg_busy[l*N_SEG +: N_SEG] & span);
  end

  // Lowest free lane wins.
  always_comb begin
    found = 1'b0;
    lane  = '0;
    for (int l = N_LANE - 1; l >= 0; l--) begin
      if (lane_ok[l]) begin
        found = 1'b1;
        lane  = LW'(l);
      end
    end
  end
endmodule

// File: rtl/rmb_prio_pick.sv
module rmb_prio_pick #(
  parameter int W = 6
)(
  input  logic [W-1:0] cand,
  output logic [W-1:0] win
);
  // Isolate the lowest set bit: lowest element index first.
  assign win = cand & (~cand + W'(1));
endmodule

// File: rtl/rmb_pe_slot.sv
module rmb_pe_slot #(
  parameter int N_PE   = 6,
  parameter int N_LANE = 3,
  parameter int SRC    = 0,
  parameter int IW     = 3,
  parameter int LW     = 2,
  parameter int N_SEG  = 5
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [LW-1:0]           take_lane,
  input  logic [IW-1:0]           take_dst,
  input  logic [N_SEG-1:0]        take_span,
  input  logic                    rel,
  output logic                    hold,
  output logic [N_LANE*N_SEG-1:0] path_seg,
  output logic [N_LANE*N_PE-1:0]  path_tap
);
  logic             hold_q, hold_d;
  logic [LW-1:0]    lane_q, lane_d;
  logic [IW-1:0]    dst_q, dst_d;
  logic [N_SEG-1:0] span_q, span_d;
  logic             en;

  // Next state: take a new path, or drop the held one on release.
  always_comb begin
    en     = take | (rel & hold_q);
    hold_d = take;
    lane_d = take ? take_lane : lane_q;
    dst_d  = take ? take_dst  : dst_q;
    span_d = take ? take_span : span_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      lane_q <= '0;
      dst_q  <= '0;
      span_q <= '0;
    end else if (en) begin
      hold_q <= hold_d;
      lane_q <= lane_d;
      dst_q  <= dst_d;
      span_q <= span_d;
    end
  end

  assign hold = hold_q;

  // Switch contributions of this element's path, one column slice per lane.
  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    logic on_lane;
    assign on_lane = hold_q && (lane_q == LW'(l));
    assign path_seg[l*N_SEG +: N_SEG] = on_lane ? span_q : '0;
    for (genvar p = 0; p < N_PE; p++) begin : g_col
      assign path_tap[l*N_PE+p] = on_lane && ((p == SRC) || (dst_q == IW'(p)));
    end
  end

  // R6: a new path is never written over a held one
  p_take_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !hold_q);

  // R2: a grant is recorded on the granted lane
  p_take_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> hold_q && (lane_q == $past(take_lane)));

  // R7: release drops the path on the next cycle
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && hold_q) |=> !hold_q);

  // R7: without release a held path is never altered
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !rel) |=> hold_q && $stable(lane_q) && $stable(span_q) && $stable(dst_q));
endmodule

// File: rtl/rmb_interconnect.sv
module rmb_interconnect
  import rmb_pkg::*;
#(
  parameter int  N_PE   = 6,
  parameter int  N_LANE = 3,
  localparam int IW     = idx_width(N_PE),
  localparam int LW     = idx_width(N_LANE),
  localparam int N_SEG  = N_PE - 1
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PE-1:0]         req_valid,
  input  logic [N_PE*IW-1:0]      req_dst,
  input  logic [N_PE-1:0]         req_rel,
  output logic [N_PE-1:0]         gnt,
  output logic [N_PE-1:0]         err,
  output logic [LW-1:0]           gnt_lane,
  output logic [N_LANE*N_SEG-1:0] seg_link,
  output logic [N_LANE*N_PE-1:0]  tap
);
  localparam int NB = N_LANE * N_SEG;

  logic [1:0]             rsync_q;
  logic                   rst_n_s;
  logic [NB-1:0]          path_seg [N_PE];
  logic [N_LANE*N_PE-1:0] path_tap [N_PE];
  logic [N_SEG-1:0]       f_span   [N_PE];
  logic [LW-1:0]          f_lane   [N_PE];
  logic [N_PE-1:0]        f_found;
  logic [N_PE-1:0]        bad;
  logic [N_PE-1:0]        hold;
  logic [N_PE-1:0]        cand;
  logic [N_PE-1:0]        win;
  logic [NB-1:0]          seg_busy;
  logic [N_PE-1:0]        own [NB];

  // Reset asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  for (genvar p = 0; p < N_PE; p++) begin : g_pe
    logic [IW-1:0] dst_p;
    assign dst_p = req_dst[p*IW +: IW];

    rmb_lane_finder #(
      .N_PE(N_PE), .N_LANE(N_LANE), .SRC(p), .IW(IW), .LW(LW), .N_SEG(N_SEG)
    ) u_find (
      .dst(dst_p), .seg_busy(seg_busy), .span(f_span[p]),
      .found(f_found[p]), .lane(f_lane[p])
    );

    assign bad[p]  = hold[p] | (dst_p == IW'(p)) | (int'(dst_p) >= N_PE);
    assign cand[p] = rst_n_s & req_valid[p] & (bad[p] | f_found[p]);

    rmb_pe_slot #(
      .N_PE(N_PE), .N_LANE(N_LANE), .SRC(p), .IW(IW), .LW(LW), .N_SEG(N_SEG)
    ) u_slot (
      .clk(clk), .rst_n(rst_n_s), .take(gnt[p]), .take_lane(f_lane[p]),
      .take_dst(dst_p), .take_span(f_span[p]), .rel(req_rel[p]),
      .hold(hold[p]), .path_seg(path_seg[p]), .path_tap(path_tap[p])
    );
  end

  rmb_prio_pick #(.W(N_PE)) u_pick (.cand(cand), .win(win));

  assign gnt = win & ~bad;
  assign err = win & bad;

  // Switch outputs are the union of every held path.
  always_comb begin
    seg_busy = '0;
    tap      = '0;
    gnt_lane = '0;
    for (int p = 0; p < N_PE; p++) begin
      seg_busy = seg_busy | path_seg[p];
      tap      = tap | path_tap[p];
      if (gnt[p]) gnt_lane = gnt_lane | f_lane[p];
    end
  end
  assign seg_link = seg_busy;

  // Owner view per segment, used by the sharing check.
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < N_PE; p++) begin
        own[b][p] = path_seg[p][b];
      end
    end
  end

  // R5: one response per cycle
  p_one_resp_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({gnt, err}));

  // R5: no answerable request below the winner
  p_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|win) |-> (((win - N_PE'(1)) & cand) == '0));

  // R1: no response while reset is still being released
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_n_s |-> ((gnt == '0) && (err == '0)));

  for (genvar b = 0; b < NB; b++) begin : g_share
    // R9: a segment is owned by at most one path
    p_no_share_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
      $onehot0(own[b]));
  end
endmodule

// File: tb/sim_rmb_interconnect.sv
`timescale 1ns/1ps
module sim_rmb_interconnect;
  localparam int NP = 6;
  localparam int NL = 3;
  localparam int IW = 3;
  localparam int LW = 2;
  localparam int NS = NP - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0]    req_valid, req_rel, gnt, err;
  logic [NP*IW-1:0] req_dst;
  logic [LW-1:0]    gnt_lane;
  logic [NL*NS-1:0] seg_link;
  logic [NL*NP-1:0] tap;

  always #2 clk = ~clk;

  rmb_interconnect #(.N_PE(NP), .N_LANE(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
    .req_rel(req_rel), .gnt(gnt), .err(err), .gnt_lane(gnt_lane),
    .seg_link(seg_link), .tap(tap)
  );

  typedef struct { int pe; bit is_err; int lane; string tag; } exp_t;
  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   live  = 1'b0;
  bit   done  = 1'b0;
  bit   m_hold [NP];
  int   m_lane [NP];
  int   m_dst  [NP];

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] model_seg();
    logic [63:0] v = '0;
    for (int p = 0; p < NP; p++) begin
      if (m_hold[p]) begin
        for (int j = 0; j < NS; j++) begin
          if (j >= ((p < m_dst[p]) ? p : m_dst[p]) && j < ((p < m_dst[p]) ? m_dst[p] : p))
            v[m_lane[p]*NS + j] = 1'b1;
        end
      end
    end
    return v;
  endfunction

  function automatic logic [63:0] model_tap();
    logic [63:0] v = '0;
    for (int p = 0; p < NP; p++) begin
      if (m_hold[p]) begin
        v[m_lane[p]*NP + p]        = 1'b1;
        v[m_lane[p]*NP + m_dst[p]] = 1'b1;
      end
    end
    return v;
  endfunction

  function automatic int model_span_len();
    int n = 0;
    for (int p = 0; p < NP; p++)
      if (m_hold[p]) n += (p < m_dst[p]) ? (m_dst[p] - p) : (p - m_dst[p]);
    return n;
  endfunction

  function automatic int pick_lane(int s, int d);
    logic [63:0] occ = model_seg();
    int lo = (s < d) ? s : d;
    int hi = (s < d) ? d : s;
    for (int l = 0; l < NL; l++) begin
      bit ok = 1'b1;
      for (int j = lo; j < hi; j++) if (occ[l*NS + j]) ok = 1'b0;
      if (ok) return l;
    end
    return -1;
  endfunction

  task automatic expect_gnt(int pe, int d, string tag);
    exp_t e;
    e.pe = pe; e.is_err = 1'b0; e.lane = pick_lane(pe, d); e.tag = tag;
    q.push_back(e);
    m_hold[pe] = 1'b1; m_lane[pe] = e.lane; m_dst[pe] = d;
  endtask

  task automatic expect_err(int pe, string tag);
    exp_t e;
    e.pe = pe; e.is_err = 1'b1; e.lane = 0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk_state(string tag);
    check({tag, " seg_link"}, 64'(seg_link), model_seg());
    check({tag, " tap"}, 64'(tap), model_tap());
    check({tag, " R9 no shared segment"}, 64'($countones(seg_link)), 64'(model_span_len()));
  endtask

  task automatic one_req(int pe, int d, bit is_e, string tag);
    @(negedge clk);
    req_valid[pe] = 1'b1;
    req_dst[pe*IW +: IW] = IW'(d);
    if (is_e) expect_err(pe, tag);
    else      expect_gnt(pe, d, tag);
    @(negedge clk);
    req_valid[pe] = 1'b0;
    chk_state(tag);
  endtask

  task automatic no_pulse(string tag);
    #1;
    check({tag, " no pulse"}, 64'({gnt, err}), 64'd0);
  endtask

  // Monitor: pops one expected response per observed pulse.
  always @(negedge clk) begin
    #1;
    if (live && (|gnt || |err)) begin
      int pe_seen;
      exp_t e;
      pe_seen = -1;
      if ($countones({gnt, err}) != 1)
        check("R5 single response", 64'($countones({gnt, err})), 64'd1);
      for (int p = NP - 1; p >= 0; p--) if (gnt[p] || err[p]) pe_seen = p;
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4/R5 unexpected response act=pe%0d exp=none", pe_seen);
      end else begin
        e = q.pop_front();
        check({e.tag, " pe"}, 64'(pe_seen), 64'(e.pe));
        check({e.tag, " kind"}, 64'(err[pe_seen]), 64'(e.is_err));
        if (!e.is_err) check({e.tag, " lane"}, 64'(gnt_lane), 64'(e.lane));
      end
    end
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_hold[p] = 0; m_lane[p] = 0; m_dst[p] = 0; end
    rst_n = 1'b0; req_valid = '0; req_rel = '0; req_dst = '0;
    repeat (3) @(negedge clk);
    req_valid[1] = 1'b1; req_dst[1*IW +: IW] = 3'd4;
    #1;
    check("R1 reset seg_link", 64'(seg_link), 64'd0);
    check("R1 reset tap", 64'(tap), 64'd0);
    check("R1 reset pulses", 64'({gnt, err}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 sync release pulses", 64'({gnt, err}), 64'd0);
    @(negedge clk);
    req_valid = '0;
    live = 1'b1;
    @(negedge clk);
    chk_state("R1 after reset");

    one_req(0, 2, 1'b0, "R2 grant 0->2");
    one_req(2, 5, 1'b0, "R8 disjoint 2->5 same lane");
    one_req(1, 3, 1'b0, "R3 overlap goes to lane 1");
    one_req(4, 3, 1'b0, "R3 downward span");
    one_req(3, 0, 1'b0, "R3 third lane");

    one_req(5, 5, 1'b1, "R6 self destination");
    one_req(0, 4, 1'b1, "R6 source already holds");
    one_req(5, 7, 1'b1, "R6 destination out of range");

    // R10: release of PE4 with a grant for PE5 on other segments.
    @(negedge clk);
    req_rel[4] = 1'b1; req_valid[5] = 1'b1; req_dst[5*IW +: IW] = 3'd4;
    expect_gnt(5, 4, "R10 grant in release cycle");
    m_hold[4] = 1'b0;
    @(negedge clk);
    req_rel[4] = 1'b0; req_valid[5] = 1'b0;
    chk_state("R10 after joint cycle");

    // R10: request needs exactly the segments being freed.
    @(negedge clk);
    req_rel[1] = 1'b1; req_valid[4] = 1'b1; req_dst[4*IW +: IW] = 3'd2;
    m_hold[1] = 1'b0;
    no_pulse("R10 freed segments not reused same cycle");
    @(negedge clk);
    req_rel[1] = 1'b0;
    expect_gnt(4, 2, "R10 retry takes freed lane");
    @(negedge clk);
    req_valid[4] = 1'b0;
    chk_state("R10 retry state");

    // R4: span blocked on every lane.
    @(negedge clk);
    req_valid[1] = 1'b1; req_dst[1*IW +: IW] = 3'd5;
    for (int i = 0; i < 4; i++) begin
      no_pulse("R4 stalled request");
      @(negedge clk);
    end
    req_rel[3] = 1'b1;
    m_hold[3] = 1'b0;
    no_pulse("R4 stall during release");
    @(negedge clk);
    req_rel[3] = 1'b0;
    expect_gnt(1, 5, "R4 granted after release");
    @(negedge clk);
    req_valid[1] = 1'b0;
    chk_state("R4 state");

    // R7: release from an element without a path.
    @(negedge clk);
    req_rel[3] = 1'b1;
    @(negedge clk);
    req_rel[3] = 1'b0;
    chk_state("R7 ignored release");
    @(negedge clk);
    req_rel[0] = 1'b1; req_rel[2] = 1'b1;
    m_hold[0] = 1'b0; m_hold[2] = 1'b0;
    @(negedge clk);
    req_rel = '0;
    chk_state("R7 release opens path");

    // R5: three requests at once, lowest first.
    @(negedge clk);
    req_valid[0] = 1'b1; req_dst[0*IW +: IW] = 3'd0;
    req_valid[2] = 1'b1; req_dst[2*IW +: IW] = 3'd3;
    req_valid[3] = 1'b1; req_dst[3*IW +: IW] = 3'd5;
    expect_err(0, "R5 lowest index first");
    @(negedge clk);
    req_valid[0] = 1'b0;
    expect_gnt(2, 3, "R5 second in order");
    @(negedge clk);
    req_valid[2] = 1'b0;
    expect_gnt(3, 5, "R5 third in order");
    @(negedge clk);
    req_valid[3] = 1'b0;
    chk_state("R5 state");

    // R5: a stalled lower index does not block a higher one.
    @(negedge clk);
    req_rel[5] = 1'b1; m_hold[5] = 1'b0;
    @(negedge clk);
    req_rel[5] = 1'b0;
    req_valid[0] = 1'b1; req_dst[0*IW +: IW] = 3'd5;
    req_valid[5] = 1'b1; req_dst[5*IW +: IW] = 3'd4;
    expect_gnt(5, 4, "R5 stalled lower skipped");
    @(negedge clk);
    req_valid[5] = 1'b0;
    no_pulse("R5 lower still stalled");
    @(negedge clk);
    req_valid[0] = 1'b0;
    chk_state("R5 skip state");

    // Release everything.
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_rel[p] = m_hold[p];
      m_hold[p] = 1'b0;
    end
    @(negedge clk);
    req_rel = '0;
    chk_state("R7 all released");
    check("R7 empty links", 64'(seg_link), 64'd0);
    check("scoreboard drained", 64'(q.size()), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule